// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the two low address bits of a four-beat burst for a synchronous cache memory. A qualified load pulse captures a starting offset. After that, every clock edge on which the active-low step input is low moves the burst one beat further. When the step input is high, the burst is suspended and the current offset is held.

A static select input chooses between two orders. In linear order the offset counts up modulo four from the start. In interleaved order the offset is the start XOR'd with the beat number. After four steps the burst wraps back to its starting offset.

The upper address register, chip-enable qualification and the memory array sit outside this block. It sees only an already-qualified load, the load value, the step enable and the order select. The width is a parameter, with two bits as the default.

Top module: `burst_offset_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the stored start and the beat index are cleared, so after that edge `off` = 0 and `beat` = 0.
- R2: When `ld` is high at a rising edge, the next cycle shows `beat` = 0 and `off` equal to the `ld_off` value that was sampled.
- R3: At a rising edge with `ld` low and `step_n` low, `beat` increments by one, modulo 2^W.
- R4: At a rising edge with `ld` low and `step_n` high, `beat` and the stored start are unchanged. With `ilv_sel` held, `off` is therefore unchanged too.
- R5: With `ilv_sel` = 0 (linear), `off` = (start + `beat`) mod 2^W. For example, a start of 01 gives 01, 10, 11, 00.
- R6: With `ilv_sel` = 1 (interleaved), `off` = start XOR `beat`. For example, a start of 10 gives 10, 11, 00, 01, and a start of 11 gives 11, 10, 01, 00.
- R7: When `ld` and a low `step_n` arrive at the same edge, the load wins: `beat` becomes 0 and `off` becomes the new start.
- R8: After 2^W consecutive steps with no load in between, `off` is back at the loaded start value in either order.
- R9: `off` follows `ilv_sel` within the same cycle without any clock edge. The stored state is not changed by toggling the select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Qualified load pulse that starts a burst |
| ld_off | input | W | Starting offset captured on load |
| step_n | input | 1 | Advance enable, active low |
| ilv_sel | input | 1 | Order select: 1 = interleaved, 0 = linear |
| off | output | W | Current burst offset |
| beat | output | W | Beat index within the burst |

## Verification
The bench builds the block with the default width of two bits, so a burst has only four beats. At that size the bench can load every start value in both orders and run each burst all the way through its wrap. It also covers suspensions in mid-burst, a load that collides with a step, and a reload in mid-burst. The order select is toggled between edges to show that the offset changes while the stored start and beat index stay put.

// File: rtl/burst_offset_seq.sv
module burst_offset_seq #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_off,
  input  logic         step_n,
  input  logic         ilv_sel,
  output logic [W-1:0] off,
  output logic [W-1:0] beat
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] start_q;
  logic [W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (ld) begin
      start_q <= ld_off;
      beat_q  <= '0;
    end else if (!step_n) begin
      beat_q  <= beat_q + ONE;
    end
  end

  assign beat = beat_q;
  assign off  = ilv_sel ? (start_q ^ beat_q) : (start_q + beat_q);

endmodule

module burst_offset_seq_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         ld,
  input logic [W-1:0] ld_off,
  input logic         step_n,
  input logic         ilv_sel,
  input logic [W-1:0] off,
  input logic [W-1:0] beat
);

  logic [W-1:0] shadow_start;

  always_ff @(posedge clk) begin
    if (rst)     shadow_start <= '0;
    else if (ld) shadow_start <= ld_off;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (off == '0 && beat == '0));

  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    ld |=> (beat == '0 && off == $past(ld_off)));

  a_r3_step_count: assert property (@(posedge clk) disable iff (rst)
    (!ld && !step_n) |=> (beat == W'($past(beat) + 1)));

  a_r4_hold_beat: assert property (@(posedge clk) disable iff (rst)
    (!ld && step_n) |=> $stable(beat));

  a_r5_linear_order: assert property (@(posedge clk) disable iff (rst)
    !ilv_sel |-> (off == W'(shadow_start + beat)));

  a_r6_interleaved_order: assert property (@(posedge clk) disable iff (rst)
    ilv_sel |-> (off == (shadow_start ^ beat)));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    (ld && !step_n) |=> (beat == '0));

endmodule

bind burst_offset_seq burst_offset_seq_chk #(.W(W)) u_chk (.*);

// File: tb/burst_offset_seq_test.sv
`timescale 1ns/1ps
module burst_offset_seq_test;

  localparam int W = 2;
  localparam int N = 1 << W;

  logic clk = 0;
  logic rst = 1;
  logic ld = 0;
  logic [W-1:0] ld_off = '0;
  logic step_n = 1;
  logic ilv_sel = 1;
  logic [W-1:0] off, beat;

  int checks = 0;
  int fails = 0;
  int m_start = 0;
  int m_beat = 0;

  always #4 clk = ~clk;

  burst_offset_seq #(.W(W)) uut (
    .clk(clk), .rst(rst), .ld(ld), .ld_off(ld_off), .step_n(step_n),
    .ilv_sel(ilv_sel), .off(off), .beat(beat)
  );

  function automatic int exp_off();
    if (ilv_sel) return m_start ^ m_beat;
    return (m_start + m_beat) % N;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp(input string req);
    chk({req, " off"}, int'(off), exp_off());
    chk({req, " beat"}, int'(beat), m_beat);
  endtask

  task automatic cyc(input bit l, input int v, input bit sn, input string req);
    ld = l; ld_off = W'(v); step_n = sn;
    @(posedge clk);
    if (rst) begin m_start = 0; m_beat = 0; end
    else if (l) begin m_start = v; m_beat = 0; end
    else if (!sn) m_beat = (m_beat + 1) % N;
    @(negedge clk);
    cmp(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc(0, 0, 1, "R1");
    rst = 0;
    cyc(0, 0, 1, "R1");

    for (int md = 0; md < 2; md++) begin
      ilv_sel = md[0];
      for (int s = 0; s < N; s++) begin
        cyc(1, s, 1, "R2");
        for (int k = 0; k < N; k++)
          cyc(0, 0, 0, md ? "R6 R3" : "R5 R3");
        chk("R8 wrap", int'(off), s);
      end
    end

    ilv_sel = 0;
    cyc(1, 1, 1, "R2");
    cyc(0, 0, 0, "R3");
    repeat (3) cyc(0, 0, 1, "R4");
    cyc(0, 0, 0, "R5");
    cyc(1, 3, 0, "R7");
    cyc(0, 0, 0, "R5");
    ilv_sel = 1;
    #1 cmp("R9");
    ilv_sel = 0;
    #1 cmp("R9");
    ilv_sel = 1;
    cyc(0, 0, 1, "R4");
    cyc(1, 2, 0, "R7");
    cyc(0, 0, 0, "R6");
    cyc(0, 2, 0, "R6");
    rst = 1;
    cyc(0, 0, 0, "R1");
    rst = 0;
    cyc(0, 0, 1, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule